// File: doc/BRIEF.md
# SD/MMC Host Status and Interrupt Register

This block gathers the event and error pulses of an SD/MMC host controller into one 32-bit status word and decides whether the host interrupt line is raised. Each event (card inserted or removed, SDIO card interrupt, command response received, write finished, read finished) and each error (response timeout, response CRC, read timeout, read CRC, write CRC) sets a sticky bit at a fixed position. Software clears a sticky bit by writing a 1 to it. Two buffer-ready flags in the same word follow the data buffer state and are not sticky. A two-bit code that qualifies a write-CRC error also sits in the word.

A second register holds interrupt enables. Their layout does not match the status layout, so a fixed routing table connects them. Errors have no enables of their own. Each error raises the interrupt under the enable of the completion that it terminates. The interrupt output is registered. The wake-up enables and the DAT0 enable are stored for neighbouring logic and never gate this line.

Software reaches both registers through a single-cycle write strobe, a one-bit register select and a combinational read port.

Top module: `sdh_stat_irq`

## Requirements
- R1: After reset the status word, the write-CRC code, the enable register and `irq` are all 0.
- R2: A one-cycle event pulse sets its status bit on the next clock edge, and the bit stays set. The positions are: card in 31, card out 30, SDIO 14, command response 13, write done 12, read done 11, response CRC error 5, read CRC error 3, write CRC error 2, response timeout 1, read timeout 0. The error bits together form mask 0x2F.
- R3: A write with `reg_sel`=0 clears every sticky bit whose `reg_wdata` bit is 1 and leaves the bits written 0 unchanged. If an event for a bit arrives in the same cycle as a write that clears it, the bit stays set.
- R4: Status bit 7 shows `buf_rd_rdy` and bit 6 shows `buf_wr_rdy`, each as sampled on the previous clock edge. A status write has no effect on either bit.
- R5: Status bits 10:9 latch `wr_crc_code` in the cycle `ev_wr_crc_err` pulses. Code value 2 means the card returned no CRC status. The code returns to 0 when a status write clears bit 2 with no new write-CRC error in that cycle. Writes to bits 10:9 are ignored.
- R6: Status bits 29:15, 8 and 4 always read 0.
- R7: A write with `reg_sel`=1 loads the enable register through the writable mask 0x0007_F01F, so every other bit reads 0. Reading with `reg_sel`=1 returns the enable register.
- R8: Each event bit is gated by its own enable bit. The pairs are status 31 with enable 15, 30 with 14, 14 with 13, 13 with 2, 12 with 1, 11 with 0, 7 with 4, and 6 with 3.
- R9: Response errors (status bits 5 and 1) raise the interrupt under enable bit 2. Read errors (bits 3 and 0) raise it under enable bit 0. The write-CRC error (bit 2) raises it under enable bit 1.
- R10: `irq` is a register. It reflects the status and enable values of the previous cycle, so it goes high one cycle after the bit it depends on becomes visible. Enable bits 18:16 and 12 never affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_sel | input | 1 | 0 selects the status word, 1 selects the enable register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| ev_card_in | input | 1 | Card insertion pulse |
| ev_card_out | input | 1 | Card removal pulse |
| ev_sdio | input | 1 | SDIO card interrupt pulse |
| ev_cmd_done | input | 1 | Command response received pulse |
| ev_wr_done | input | 1 | Write operation finished pulse |
| ev_rd_done | input | 1 | Read or transfer finished pulse |
| ev_resp_crc_err | input | 1 | Response CRC error pulse |
| ev_rd_crc_err | input | 1 | Read data CRC error pulse |
| ev_wr_crc_err | input | 1 | Write CRC status error pulse |
| ev_resp_tmo | input | 1 | Response timeout pulse |
| ev_rd_tmo | input | 1 | Read data timeout pulse |
| wr_crc_code | input | 2 | Write-CRC qualifier, sampled with `ev_wr_crc_err` |
| buf_rd_rdy | input | 1 | Buffer holds data to read (level) |
| buf_wr_rdy | input | 1 | Buffer has room to write (level) |
| irq | output | 1 | Registered host interrupt |

## Verification
An event pulse and a write-1 clear of the same bit can meet in one cycle. A new write-CRC error and the clear of bit 2 that would also reset the qualifier code can meet the same way. Random stimulus provokes both collisions: events are pulsed often while status writes carry random masks. Directed cycles force each collision on purpose. In each case the bench checks that the bit, and the freshly latched code, remain visible at the read port and that the interrupt follows one cycle later.

// File: rtl/sdh_stat_pkg.sv
package sdh_stat_pkg;
  localparam int unsigned WORD_W = 32;

  // status positions
  localparam int unsigned S_CARD_IN   = 31;
  localparam int unsigned S_CARD_OUT  = 30;
  localparam int unsigned S_SDIO      = 14;
  localparam int unsigned S_CMD_DONE  = 13;
  localparam int unsigned S_WR_DONE   = 12;
  localparam int unsigned S_RD_DONE   = 11;
  localparam int unsigned S_CODE_LO   = 9;
  localparam int unsigned S_BUF_RD    = 7;
  localparam int unsigned S_BUF_WR    = 6;
  localparam int unsigned S_RESP_CRC  = 5;
  localparam int unsigned S_RD_CRC    = 3;
  localparam int unsigned S_WR_CRC    = 2;
  localparam int unsigned S_RESP_TMO  = 1;
  localparam int unsigned S_RD_TMO    = 0;

  localparam logic [WORD_W-1:0] ERR_MASK    = 32'h0000_002F;
  localparam logic [WORD_W-1:0] STICKY_MASK = 32'hC000_7800 | ERR_MASK;

  // enable positions
  localparam int unsigned E_CARD_IN  = 15;
  localparam int unsigned E_CARD_OUT = 14;
  localparam int unsigned E_SDIO     = 13;
  localparam int unsigned E_BUF_RD   = 4;
  localparam int unsigned E_BUF_WR   = 3;
  localparam int unsigned E_CMD      = 2;
  localparam int unsigned E_WR       = 1;
  localparam int unsigned E_RD       = 0;
  localparam logic [WORD_W-1:0] EN_WR_MASK = 32'h0007_F01F;

  localparam int unsigned N_SRC = 8;

  // Per-source pending terms; errors fold into the completion they end.
  function automatic logic [N_SRC-1:0] irq_terms(input logic [WORD_W-1:0] st,
                                                 input logic [WORD_W-1:0] en);
    logic [N_SRC-1:0] t;
    t[0] = st[S_CARD_IN]  & en[E_CARD_IN];
    t[1] = st[S_CARD_OUT] & en[E_CARD_OUT];
    t[2] = st[S_SDIO]     & en[E_SDIO];
    t[3] = (st[S_CMD_DONE] | st[S_RESP_CRC] | st[S_RESP_TMO]) & en[E_CMD];
    t[4] = (st[S_WR_DONE] | st[S_WR_CRC]) & en[E_WR];
    t[5] = (st[S_RD_DONE] | st[S_RD_CRC] | st[S_RD_TMO]) & en[E_RD];
    t[6] = st[S_BUF_RD]   & en[E_BUF_RD];
    t[7] = st[S_BUF_WR]   & en[E_BUF_WR];
    return t;
  endfunction

  // Sticky next state: clear first, then set, so a coincident set wins.
  function automatic logic sticky_next(input logic cur, input logic set,
                                       input logic clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/sdh_sticky_bank.sv
module sdh_sticky_bank #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);
  import sdh_stat_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[i] <= 1'b0;
      else if (MASK[i])
        q[i] <= sticky_next(q[i], set_vec[i], clr_vec[i]);
      else
        q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/sdh_crc_code.sv
module sdh_crc_code #(
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [CW-1:0] code_in,
  input  logic          drop,
  output logic [CW-1:0] code_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (capture) code_q <= code_in;
    else if (drop)    code_q <= '0;
  end
endmodule

// File: rtl/sdh_en_reg.sv
module sdh_en_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] WMASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= wdata & WMASK;
  end
endmodule

// File: rtl/sdh_irq_gen.sv
module sdh_irq_gen #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat,
  input  logic [W-1:0] en,
  output logic         irq
);
  import sdh_stat_pkg::*;

  logic [N_SRC-1:0] terms;
  assign terms = irq_terms(stat, en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |terms;
  end
endmodule

// File: rtl/sdh_stat_irq.sv
module sdh_stat_irq
  import sdh_stat_pkg::*;
#(
  parameter int unsigned DW = WORD_W,
  parameter int unsigned CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              ev_card_in,
  input  logic              ev_card_out,
  input  logic              ev_sdio,
  input  logic              ev_cmd_done,
  input  logic              ev_wr_done,
  input  logic              ev_rd_done,
  input  logic              ev_resp_crc_err,
  input  logic              ev_rd_crc_err,
  input  logic              ev_wr_crc_err,
  input  logic              ev_resp_tmo,
  input  logic              ev_rd_tmo,
  input  logic [CODE_W-1:0] wr_crc_code,
  input  logic              buf_rd_rdy,
  input  logic              buf_wr_rdy,
  output logic              irq
);
  // named internal events
  logic [DW-1:0]     ev_vec;
  logic [DW-1:0]     clr_vec;
  logic              stat_wr;
  logic              en_wr;
  logic              code_drop;
  logic [DW-1:0]     sticky_q;
  logic [DW-1:0]     en_q;
  logic [DW-1:0]     stat_rd;
  logic [CODE_W-1:0] code_q;
  logic [1:0]        lvl_q;

  assign stat_wr = reg_wr & ~reg_sel;
  assign en_wr   = reg_wr &  reg_sel;
  assign clr_vec = stat_wr ? reg_wdata : '0;

  always_comb begin
    ev_vec              = '0;
    ev_vec[S_CARD_IN]   = ev_card_in;
    ev_vec[S_CARD_OUT]  = ev_card_out;
    ev_vec[S_SDIO]      = ev_sdio;
    ev_vec[S_CMD_DONE]  = ev_cmd_done;
    ev_vec[S_WR_DONE]   = ev_wr_done;
    ev_vec[S_RD_DONE]   = ev_rd_done;
    ev_vec[S_RESP_CRC]  = ev_resp_crc_err;
    ev_vec[S_RD_CRC]    = ev_rd_crc_err;
    ev_vec[S_WR_CRC]    = ev_wr_crc_err;
    ev_vec[S_RESP_TMO]  = ev_resp_tmo;
    ev_vec[S_RD_TMO]    = ev_rd_tmo;
  end

  sdh_sticky_bank #(.W(DW), .MASK(STICKY_MASK)) u_sticky (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (ev_vec),
    .clr_vec (clr_vec),
    .q       (sticky_q)
  );

  assign code_drop = clr_vec[S_WR_CRC];

  sdh_crc_code #(.CW(CODE_W)) u_code (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (ev_wr_crc_err),
    .code_in (wr_crc_code),
    .drop    (code_drop),
    .code_q  (code_q)
  );

  // buffer level flags: sampled, never cleared by software
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= {buf_rd_rdy, buf_wr_rdy};
  end

  sdh_en_reg #(.W(DW), .WMASK(EN_WR_MASK)) u_en (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (en_wr),
    .wdata (reg_wdata),
    .q     (en_q)
  );

  always_comb begin
    stat_rd = sticky_q;
    stat_rd[S_BUF_RD] = lvl_q[1];
    stat_rd[S_BUF_WR] = lvl_q[0];
    stat_rd[S_CODE_LO +: CODE_W] = code_q;
  end

  assign reg_rdata = reg_sel ? en_q : stat_rd;

  sdh_irq_gen #(.W(DW)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .stat  (stat_rd),
    .en    (en_q),
    .irq   (irq)
  );
endmodule

// File: rtl/sdh_stat_irq_chk.sv
module sdh_stat_irq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        stat_wr,
  input logic [31:0] clr_vec,
  input logic [31:0] ev_vec,
  input logic [31:0] stat_rd,
  input logic [31:0] en_q,
  input logic        ev_wr_crc_err,
  input logic [1:0]  wr_crc_code,
  input logic        buf_rd_rdy,
  input logic        irq
);
  // R2: an event shows at its position after the edge
  p_cmd_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vec[13] |=> stat_rd[13]);

  // R3: set beats a coincident clear
  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vec[0] && clr_vec[0]) |=> stat_rd[0]);

  // R3: clear without an event empties the bit
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && clr_vec[31] && !ev_vec[31]) |=> !stat_rd[31]);

  // R3: no write, no event -> sticky bits hold
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_wr && ev_vec == 32'd0) |=> ((stat_rd & 32'hC000_782F) == ($past(stat_rd) & 32'hC000_782F)));

  // R4: read-ready level follows its input one edge later
  p_lvl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_rd[7] == $past(buf_rd_rdy)));

  // R5: code captured with the write-CRC error
  p_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_crc_err |=> (stat_rd[10:9] == $past(wr_crc_code)));

  // R6: unused status bits stay low
  p_unused_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd & 32'h3FFF_8110) == 32'd0);

  // R8: enabled command response raises the line next cycle
  p_cmd_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd[13] && en_q[2]) |=> irq);

  // R10: nothing pending and nothing enabled -> line low next cycle
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[15:0] == 16'd0) |=> !irq);
endmodule

bind sdh_stat_irq sdh_stat_irq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .stat_wr       (stat_wr),
  .clr_vec       (clr_vec),
  .ev_vec        (ev_vec),
  .stat_rd       (stat_rd),
  .en_q          (en_q),
  .ev_wr_crc_err (ev_wr_crc_err),
  .wr_crc_code   (wr_crc_code),
  .buf_rd_rdy    (buf_rd_rdy),
  .irq           (irq)
);

// File: tb/sim_sdh_stat_irq.sv
module sim_sdh_stat_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ev_card_in = 0, ev_card_out = 0, ev_sdio = 0, ev_cmd_done = 0;
  logic        ev_wr_done = 0, ev_rd_done = 0, ev_resp_crc_err = 0, ev_rd_crc_err = 0;
  logic        ev_wr_crc_err = 0, ev_resp_tmo = 0, ev_rd_tmo = 0;
  logic [1:0]  wr_crc_code = '0;
  logic        buf_rd_rdy = 0, buf_wr_rdy = 0;
  logic        irq;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  // bench model
  logic [31:0] m_sticky = '0, m_en = '0;
  logic [1:0]  m_code = '0, m_lvl = '0;

  always #4 clk = ~clk;

  sdh_stat_irq u0 (.*);

  function automatic logic [31:0] m_stat();
    logic [31:0] s = m_sticky;
    s[10:9] = m_code;
    s[7] = m_lvl[1];
    s[6] = m_lvl[0];
    return s;
  endfunction

  function automatic logic exp_irq(input logic [31:0] s, input logic [31:0] e);
    logic cmd_side, wr_side, rd_side, misc;
    cmd_side = e[2] & (s[13] | s[5] | s[1]);
    wr_side  = e[1] & (s[12] | s[2]);
    rd_side  = e[0] & (s[11] | s[3] | s[0]);
    misc = (e[15] & s[31]) | (e[14] & s[30]) | (e[13] & s[14])
         | (e[4] & s[7]) | (e[3] & s[6]);
    return cmd_side | wr_side | rd_side | misc;
  endfunction

  function automatic logic [31:0] ev_word();
    return {ev_card_in, ev_card_out, 15'd0, ev_sdio, ev_cmd_done, ev_wr_done,
            ev_rd_done, 5'd0, ev_resp_crc_err, 1'b0, ev_rd_crc_err,
            ev_wr_crc_err, ev_resp_tmo, ev_rd_tmo};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    reg_wr = 0; reg_wdata = '0;
    {ev_card_in, ev_card_out, ev_sdio, ev_cmd_done, ev_wr_done, ev_rd_done,
     ev_resp_crc_err, ev_rd_crc_err, ev_wr_crc_err, ev_resp_tmo, ev_rd_tmo} = '0;
    wr_crc_code = '0;
  endtask

  // One clock with the currently driven inputs; model, then compare.
  task automatic cyc(input string req);
    logic e_irq;
    logic [31:0] clr;
    e_irq = exp_irq(m_stat(), m_en);
    clr = (reg_wr && !reg_sel) ? reg_wdata : 32'd0;
    m_sticky = ((m_sticky & ~clr) | ev_word()) & 32'hC000_782F;
    if (ev_wr_crc_err) m_code = wr_crc_code;
    else if (clr[2])   m_code = 2'd0;
    m_lvl = {buf_rd_rdy, buf_wr_rdy};
    if (reg_wr && reg_sel) m_en = reg_wdata & 32'h0007_F01F;
    @(posedge clk);
    @(negedge clk);
    check(req, reg_rdata, reg_sel ? m_en : m_stat());
    check({req, " irq R10"}, {31'd0, irq}, {31'd0, e_irq});
    clear_inputs();
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 status", reg_rdata, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    reg_sel = 1; cyc("R1 enable");
    reg_sel = 0;

    // R2: each event position
    ev_card_in = 1; cyc("R2 card in");
    ev_card_out = 1; ev_sdio = 1; cyc("R2 out/sdio");
    ev_cmd_done = 1; ev_wr_done = 1; ev_rd_done = 1; cyc("R2 done bits");
    ev_resp_crc_err = 1; ev_rd_crc_err = 1; ev_resp_tmo = 1; ev_rd_tmo = 1; cyc("R2 errors");
    cyc("R2 sticky hold");
    // R3: write 0 leaves, write 1 clears
    reg_wr = 1; reg_wdata = 32'd0; cyc("R3 write zero");
    reg_wr = 1; reg_wdata = 32'hFFFF_FFFF; cyc("R3 clear all");
    // R3: set wins over clear
    ev_rd_tmo = 1; ev_card_in = 1; reg_wr = 1; reg_wdata = 32'hFFFF_FFFF; cyc("R3 set wins");
    reg_wr = 1; reg_wdata = 32'h8000_0001; cyc("R3 clear after");
    // R4: levels follow, writes ignored
    buf_rd_rdy = 1; buf_wr_rdy = 1; cyc("R4 levels up");
    reg_wr = 1; reg_wdata = 32'h0000_00C0; cyc("R4 write ignored");
    buf_wr_rdy = 0; cyc("R4 wr level drops");
    buf_rd_rdy = 0; cyc("R4 rd level drops");
    // R5: code capture, no-CRC code 2, drop on clear, collision
    ev_wr_crc_err = 1; wr_crc_code = 2'd2; cyc("R5 no-crc code");
    reg_wr = 1; reg_wdata = 32'h0000_0600; cyc("R5 code write ignored");
    reg_wr = 1; reg_wdata = 32'h0000_0004; ev_wr_crc_err = 1; wr_crc_code = 2'd1; cyc("R5 capture beats drop");
    reg_wr = 1; reg_wdata = 32'h0000_0004; cyc("R5 drop");
    // R6 unused bits after random write with all events
    ev_card_in = 1; ev_card_out = 1; ev_sdio = 1; cyc("R6 unused zero");
    reg_wr = 1; reg_wdata = 32'hFFFF_FFFF; cyc("R6 clean");
    // R7 enable mask
    reg_sel = 1; reg_wr = 1; reg_wdata = 32'hFFFF_FFFF; cyc("R7 en mask");
    reg_sel = 1; reg_wr = 1; reg_wdata = 32'h0007_1000; cyc("R7 wake and dat0");
    // R10: wake/DAT0 enables with all pending give no irq
    reg_sel = 1; ev_card_in = 1; ev_sdio = 1; ev_cmd_done = 1; ev_rd_tmo = 1; cyc("R10 wake no irq");
    reg_sel = 1; cyc("R10 still quiet");
    reg_sel = 0; reg_wr = 1; reg_wdata = 32'hFFFF_FFFF; cyc("R10 clean");
    // R8: each pair
    reg_sel = 1; reg_wr = 1; reg_wdata = 32'h0000_0004; cyc("R8 en cmd");
    reg_sel = 0; ev_cmd_done = 1; cyc("R8 cmd set");
    cyc("R8 cmd irq");
    reg_wr = 1; reg_wdata = 32'h0000_2000; cyc("R8 clear");
    cyc("R8 irq drop");
    // R9: error routing
    ev_resp_tmo = 1; cyc("R9 resp tmo");
    cyc("R9 resp tmo irq");
    reg_wr = 1; reg_wdata = 32'h2; cyc("R9 clear");
    ev_rd_crc_err = 1; cyc("R9 rd crc under cmd en");
    cyc("R9 no irq");
    reg_sel = 1; reg_wr = 1; reg_wdata = 32'h0000_0001; cyc("R9 en rd");
    reg_sel = 0; cyc("R9 rd crc irq");
    cyc("R9 rd crc irq held");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      ev_card_in      = (r[2:0] == 0);
      ev_card_out     = (r[5:3] == 0);
      ev_sdio         = (r[8:6] == 0);
      ev_cmd_done     = (r[11:9] == 0);
      ev_wr_done      = (r[14:12] == 0);
      ev_rd_done      = (r[17:15] == 0);
      ev_resp_crc_err = (r[20:18] == 0);
      ev_rd_crc_err   = (r[23:21] == 0);
      ev_wr_crc_err   = (r[26:24] == 0);
      ev_resp_tmo     = (r[29:27] == 0);
      ev_rd_tmo       = (r[31:30] == 0) && r[0];
      r = $urandom;
      wr_crc_code = r[1:0];
      buf_rd_rdy = r[2];
      buf_wr_rdy = r[3];
      reg_wr = (r[6:4] < 3);
      reg_sel = (r[9:7] == 0);
      reg_wdata = $urandom;
      cyc(reg_sel ? "R7 random" : "R3 random");
    end
    finished = 1;
    report();
  end
endmodule